// File: doc/BRIEF.md
# Address-masked GPIO data port

This block holds the data and direction state of a small bank of general-purpose pins behind a simple memory-mapped register bus. Each pin is set up as either an output or an input by its direction bit. Output pins drive the value stored in the data register. Input pins present a high level on the output side and feed their synchronized external level back into the data register. The current data register contents are also brought out on their own port, for the interrupt logic that sits next to the block.

The data register does not have a single address. It is reached through a window at the bottom of the address space, and the word-address bits inside that window select which data bits an access touches. Software can therefore set, clear or sample any subset of pins in one bus access, with no read-modify-write sequence. The direction register sits at the first word above the window.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the data and direction registers are zero, `bus_rdata` is zero and every `pin_out` bit is 1.
- R2: A write to byte offset 0x400 loads the direction register from the low 8 bits of `bus_wdata` (1 = output, 0 = input), and higher bits are dropped. A read of 0x400 returns the direction register, zero-extended.
- R3: A write to any offset below 0x400 changes only the data bits that are set both in the lane mask `bus_addr[9:2]` and in the direction register. Each such bit takes the matching `bus_wdata` bit, and every other output bit keeps its value.
- R4: A read of any offset below 0x400 returns the data register ANDed with the lane mask `bus_addr[9:2]`. Bits outside the mask and bits 31:8 read as zero.
- R5: `pin_out` bit i equals data bit i when direction bit i is 1, and is 1 when direction bit i is 0.
- R6: A level on `pin_in` of an input pin reaches the data register through a two-flop synchronizer. It appears on `pin_state` after the third rising clock edge following the change.
- R7: Changes on `pin_in` for pins set as outputs have no effect on the data register.
- R8: Read data is registered and appears on `bus_rdata` one cycle after the request. The bus reads zero in any cycle that follows no read.
- R9: Writes to offsets above 0x400 change neither register, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Resolved output pin levels |
| pin_state | output | 8 | Current data register, for interrupt logic |

## Verification
Register writes are due one edge after the request: the new `pin_out` and `pin_state` values are sampled at the following falling edge. Read data is also sampled at the falling edge after the request edge, and one cycle later it must be zero again. An input change takes three edges (two synchronizer flops and the data flop), so the bench samples after the second edge to confirm that the value has not arrived early, and after the third to confirm that it has arrived. A change on an output pin is watched for several cycles to confirm it is ignored. All stimulus is driven at falling edges so that no sample coincides with an update.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   // Classification of one bus request.
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_DATA  = 2'd1,
      ACC_DIR   = 2'd2,
      ACC_OTHER = 2'd3
   } acc_kind_e;

endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);

   if (STAGES == 0) begin : g_bypass
      assign d_sync = d_async;
   end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
         end else begin
            stg_q[0] <= d_async;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
         end
      end

      assign d_sync = stg_q[STAGES-1];
   end

endmodule

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic             dir_wr,
   input  logic [NPINS-1:0] lane_mask,
   input  logic [NPINS-1:0] wr_bits,
   input  logic [NPINS-1:0] pin_sync,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] dir_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_wr) dir_q <= wr_bits;
   end

   // One flop per pin: outputs take masked bus writes, inputs follow the pin.
   for (genvar i = 0; i < NPINS; i++) begin : g_bit
      logic nxt;

      always_comb begin
         if (!dir_q[i])                     nxt = pin_sync[i];
         else if (data_wr && lane_mask[i])  nxt = wr_bits[i];
         else                               nxt = data_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_q[i] <= 1'b0;
         else        data_q[i] <= nxt;
      end
   end

endmodule

// File: rtl/gpio_mask_rdmux.sv
module gpio_mask_rdmux
   import gpio_mask_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  acc_kind_e         kind,
   input  logic [NPINS-1:0]  lane_mask,
   input  logic [NPINS-1:0]  data_q,
   input  logic [NPINS-1:0]  dir_q,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] sel;

   always_comb begin
      unique case (kind)
         ACC_DATA: sel = DATA_W'(data_q & lane_mask);
         ACC_DIR:  sel = DATA_W'(dir_q);
         default:  sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel;
      else            rdata <= '0;
   end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_state
);

   // The lane mask occupies the word-address bits directly below the window top.
   localparam int              WIN_BIT  = NPINS + 2;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << WIN_BIT;

   if (NPINS < 1 || NPINS > 8) begin : g_bad_npins
      $error("gpio_mask_port: NPINS must be 1..8");
   end
   if (ADDR_W <= WIN_BIT) begin : g_bad_addr
      $error("gpio_mask_port: ADDR_W too small for data window and direction word");
   end
   if (DATA_W <= NPINS) begin : g_bad_data
      $error("gpio_mask_port: DATA_W must exceed NPINS");
   end

   acc_kind_e        kind;
   logic [NPINS-1:0] lane_mask;
   logic [NPINS-1:0] pin_sync;
   logic [NPINS-1:0] data_q;
   logic [NPINS-1:0] dir_q;
   logic             unused_wdata;

   assign lane_mask    = bus_addr[WIN_BIT-1:2];
   assign unused_wdata = ^bus_wdata[DATA_W-1:NPINS];

   always_comb begin
      if (!bus_valid)                          kind = ACC_IDLE;
      else if (bus_addr[ADDR_W-1:WIN_BIT] == '0) kind = ACC_DATA;
      else if (bus_addr == DIR_ADDR)           kind = ACC_DIR;
      else                                     kind = ACC_OTHER;
   end

   gpio_mask_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .d_sync  (pin_sync)
   );

   gpio_mask_regs #(.NPINS(NPINS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_wr   (bus_we && kind == ACC_DATA),
      .dir_wr    (bus_we && kind == ACC_DIR),
      .lane_mask (lane_mask),
      .wr_bits   (bus_wdata[NPINS-1:0]),
      .pin_sync  (pin_sync),
      .data_q    (data_q),
      .dir_q     (dir_q)
   );

   gpio_mask_rdmux #(.NPINS(NPINS), .DATA_W(DATA_W)) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (bus_valid && !bus_we),
      .kind      (kind),
      .lane_mask (lane_mask),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .rdata     (bus_rdata)
   );

   // Pins set as inputs float high on the output side.
   for (genvar i = 0; i < NPINS; i++) begin : g_out
      assign pin_out[i] = dir_q[i] ? data_q[i] : 1'b1;
   end

   assign pin_state = data_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_state,
   input logic [NPINS-1:0]  dir_q
);

   localparam int WIN_BIT = NPINS + 2;

   logic in_win;
   logic data_wr;
   assign in_win  = bus_addr[ADDR_W-1:WIN_BIT] == '0;
   assign data_wr = bus_valid && bus_we && in_win;

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we && bus_addr == (ADDR_W'(1) << WIN_BIT))
      |=> dir_q == $past(bus_wdata[NPINS-1:0]));

   // R3
   masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> ((pin_state ^ $past(pin_state)) & $past(dir_q)
                   & ~$past(bus_addr[WIN_BIT-1:2])) == '0);

   // R7
   output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> ((pin_state ^ $past(pin_state)) & $past(dir_q)) == '0);

   // R4
   read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && in_win)
      |=> (bus_rdata & ~DATA_W'($past(bus_addr[WIN_BIT-1:2]))) == '0);

   // R8
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_we) |=> bus_rdata == '0);

   // R5
   input_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~dir_q & ~pin_out) == '0);

   // R5
   output_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ pin_state) & dir_q) == '0);

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
   .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_state (pin_state),
   .dir_q     (dir_q)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_state;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_mask_port u_gpio_mask_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_state (pin_state)
   );

   // Entry: {tag[3:0], we, addr[11:0], wdata[15:0], expected[7:0]}
   // writes expect pin_out, reads expect bus_rdata. pin_in held at 0.
   localparam int NVEC = 15;
   localparam logic [40:0] VEC [NVEC] = '{
      {4'd2, 1'b1, 12'h400, 16'h000F, 8'hF0}, // R2 dir = 0F
      {4'd2, 1'b0, 12'h400, 16'h0000, 8'h0F}, // R2 read dir
      {4'd3, 1'b1, 12'h3FC, 16'h00A5, 8'hF5}, // R3 full mask, data 05
      {4'd4, 1'b0, 12'h3FC, 16'h0000, 8'h05}, // R4
      {4'd3, 1'b1, 12'h004, 16'h0000, 8'hF4}, // R3 clear bit0
      {4'd3, 1'b1, 12'h028, 16'h00FF, 8'hFE}, // R3 set bits 1,3
      {4'd4, 1'b0, 12'h018, 16'h0000, 8'h06}, // R4 mask 06
      {4'd4, 1'b0, 12'h000, 16'h0000, 8'h00}, // R4 empty mask
      {4'd3, 1'b1, 12'h3C0, 16'h00FF, 8'hFE}, // R3 only input lanes
      {4'd9, 1'b1, 12'h404, 16'h00FF, 8'hFE}, // R9 write elsewhere
      {4'd9, 1'b0, 12'h404, 16'h0000, 8'h00}, // R9 read elsewhere
      {4'd2, 1'b1, 12'h400, 16'h01F0, 8'h0F}, // R2 bit 8 dropped
      {4'd2, 1'b0, 12'h400, 16'h0000, 8'hF0}, // R2
      {4'd5, 1'b1, 12'h3FC, 16'h00C3, 8'hCF}, // R5 upper outputs C0
      {4'd4, 1'b0, 12'h3FC, 16'h0000, 8'hC0}  // R4
   };

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
   task automatic bus_op(input logic we, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1;
      bus_we    = we;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0;
      bus_we    = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1", {24'b0, pin_out}, 32'h0000_00FF);
      check("R1", {24'b0, pin_state}, 32'h0);
      check("R1", bus_rdata, 32'h0);
      rst_n = 1'b1;
      bus_op(1'b0, 12'h3FC, 32'h0);
      check("R1", bus_rdata, 32'h0);
      bus_op(1'b0, 12'h400, 32'h0);
      check("R1", bus_rdata, 32'h0);

      for (int v = 0; v < NVEC; v++) begin
         logic [40:0] e;
         e = VEC[v];
         bus_op(e[36], e[35:24], {16'h0, e[23:8]});
         if (e[36]) check(tag_name(e[40:37]), {24'b0, pin_out}, {24'b0, e[7:0]});
         else       check(tag_name(e[40:37]), bus_rdata, {24'b0, e[7:0]});
      end

      // R8: no request in the next cycle gives zero read data
      bus_op(1'b0, 12'h3FC, 32'h0);
      check("R8", bus_rdata, 32'h0000_00C0);
      @(negedge clk);
      check("R8", bus_rdata, 32'h0);

      // R6: dir = F0, low nibble is input. Change arrives after third edge.
      pin_in = 8'h05;
      @(negedge clk);
      @(negedge clk);
      check("R6", {24'b0, pin_state}, 32'h0000_00C0);
      @(negedge clk);
      check("R6", {24'b0, pin_state}, 32'h0000_00C5);
      // R5: input pins still present high
      check("R5", {24'b0, pin_out}, 32'h0000_00CF);
      // R4: masked read of captured input bit
      bus_op(1'b0, 12'h004, 32'h0);
      check("R4", bus_rdata, 32'h0000_0001);

      // R7: flip output-pin levels; data must not follow
      pin_in = 8'h35;
      repeat (5) @(negedge clk);
      check("R7", {24'b0, pin_state}, 32'h0000_00C5);
      check("R7", {24'b0, pin_out}, 32'h0000_00CF);

      // R9: write to an offset above the direction word leaves both registers
      bus_op(1'b1, 12'h800, 32'hFFFF_FFFF);
      bus_op(1'b0, 12'h400, 32'h0);
      check("R9", bus_rdata, 32'h0000_00F0);
      check("R9", {24'b0, pin_state}, 32'h0000_00C5);

      // R1: reset in mid-run returns to the reset state
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", {24'b0, pin_out}, 32'h0000_00FF);
      check("R1", {24'b0, pin_state}, 32'h0);
      pin_in = 8'h00;
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule